// File: doc/BRIEF.md
# Two-Level Variable-Page Table Walker

This block turns a 32-bit virtual address into a physical address. The requester gives the address, whether the access is a read or a write, whether it runs privileged, and two table base addresses: one for the lower (local) half of the virtual space and one for the upper (global) half. Each accepted request is first sorted into one of three classes. Addresses in the forbidden windows fault at once. Addresses in the low 128 MiB of either half pass straight through untranslated. Everything else is looked up in a two-level page table held in memory.

A walk makes at most two word reads over a valid/ready request port that has a separate response strobe. The first-level entry describes one 4 MiB region and carries a page-size code, so the size of the second-level table and the width of the index into it change from region to region. Pages run from 4 KiB up to one 4 MiB page. The result is either a physical address with cache-window and write-combine attributes, or a fault code. It comes out with a one-cycle done strobe. Only one translation is in flight at a time.

Top module: `vpage_walker`

## Requirements
- R1: A virtual address in 0x00000000..0x001FFFFF or 0xFFFF0000..0xFFFFFFFF finishes with fault code 1 (invalid) and makes no memory read.
- R2: Any other address whose bits [30:0] are below 0x08000000 finishes with fault 0. The physical address equals the virtual address, the cache window is 0 and write-combine is 0. No memory read is made.
- R3: The first read goes to base + 4 * vaddr[30:22]. The base is the local base when vaddr[31] is 0 and the global base when it is 1. Bit 31 takes no part in the index.
- R4: If bit 0 (valid) of the first-level entry is 0, the walk ends with fault 2 (not present) after one read. If bit 0 of the second-level entry is 0, it ends with fault 2 after two reads.
- R5: The first-level entry holds a size code in bits [4:1] that gives a page shift of 12 + code. A code above 10 ends the walk with fault 5 (bad size) after one read.
- R6: The second read goes to (first-level entry with bits [11:0] cleared) + 4 * ((vaddr & 0x3FFFFF) >> shift).
- R7: On success, the physical address takes the second-level entry's bits at and above the shift and the virtual address's bits below it. The cache window is entry bits [7:6] and write-combine is entry bit 3.
- R8: If the second-level entry has bit 2 (privileged only) set and the request is unprivileged, the walk ends with fault 4. This check takes priority over the write check.
- R9: A write to a second-level entry whose bit 1 (write enable) is 0 ends with fault 3.
- R10: While the memory request is valid and not yet accepted, it stays valid and its address does not change.
- R11: The done strobe lasts exactly one cycle. The request-ready output is low from acceptance through done. A faulting result reports physical address 0, cache window 0 and write-combine 0.
- R12: After reset, request-ready is 1, and both done and the memory request valid are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request valid |
| reqReady | output | 1 | Block idle, can take a request |
| reqVaddr | input | 32 | Virtual address |
| reqWrite | input | 1 | 1 = write access |
| reqPriv | input | 1 | 1 = privileged access |
| localBase | input | 32 | First-level table base, lower half |
| globalBase | input | 32 | First-level table base, upper half |
| memReqValid | output | 1 | Table read request valid |
| memReqReady | input | 1 | Memory accepts the request |
| memReqAddr | output | 32 | Table word address |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 32 | Read data |
| doneValid | output | 1 | Result strobe, one cycle |
| donePaddr | output | 32 | Physical address |
| doneWin | output | 2 | Cache window |
| doneWc | output | 1 | Write-combine flag |
| doneFault | output | 3 | 0 ok, 1 invalid, 2 not present, 3 write protect, 4 privilege, 5 bad size |

## Verification
The assertions assume that memory gives exactly one response for each accepted request, that no response arrives without a read outstanding, and that reqVaddr and the base inputs only matter in the cycle of acceptance. The bench's memory model answers exactly one cycle after each handshake and holds memReqReady low on one cycle in three, so the hold rule is exercised. The requester offers a new address only once the previous result has been collected, so no request ever overlaps a walk.

// File: rtl/walker_pkg.sv
package walker_pkg;
  typedef enum logic [2:0] {
    FLT_NONE    = 3'd0,
    FLT_INVALID = 3'd1,
    FLT_ABSENT  = 3'd2,
    FLT_WRPROT  = 3'd3,
    FLT_PRIV    = 3'd4,
    FLT_SIZE    = 3'd5
  } fault_e;

  // entry bit positions
  localparam int ENT_VALID = 0;
  localparam int ENT_WRITE = 1;
  localparam int ENT_PRIV  = 2;
  localparam int ENT_WC    = 3;
  localparam int SIZE_LSB  = 1;
  localparam int SIZE_W    = 4;
  localparam int WIN_LSB   = 6;
  localparam int WIN_W     = 2;

  typedef struct packed {
    logic   capReq;
    logic   capL1;
    logic   capL2;
    logic   useL2;
    logic   finBypass;
    logic   finLeaf;
    logic   finFault;
    fault_e code;
  } strobe_t;
endpackage

// File: rtl/walker_dp.sv
module walker_dp
  import walker_pkg::*;
#(
  parameter int AW           = 32,
  parameter int REGION_SHIFT = 22,
  parameter int MIN_SHIFT    = 12,
  parameter int MAX_CODE     = 10,
  parameter int TBL_ALIGN    = 12,
  parameter logic [AW-1:0] INV_LO_LAST  = 32'h001F_FFFF,
  parameter logic [AW-1:0] INV_HI_FIRST = 32'hFFFF_0000,
  parameter logic [AW-1:0] BYPASS_SIZE  = 32'h0800_0000
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       st,
  input  logic [AW-1:0] reqVaddr,
  input  logic          reqWrite,
  input  logic          reqPriv,
  input  logic [AW-1:0] localBase,
  input  logic [AW-1:0] globalBase,
  input  logic [AW-1:0] memRspData,
  output logic          isInvalid,
  output logic          isBypass,
  output logic          l1Valid,
  output logic          l1SizeOk,
  output logic          l2Valid,
  output logic          privViol,
  output logic          writeViol,
  output logic [AW-1:0] memAddr,
  output logic [AW-1:0] resPaddr,
  output logic [WIN_W-1:0] resWin,
  output logic          resWc,
  output fault_e        resFault
);
  localparam logic [AW-1:0] HALF_MASK   = {1'b0, {(AW-1){1'b1}}};
  localparam logic [AW-1:0] REGION_MASK = (AW'(1) << REGION_SHIFT) - AW'(1);
  localparam logic [AW-1:0] TBL_MASK    = (AW'(1) << TBL_ALIGN) - AW'(1);

  logic [AW-1:0] vaReg, baseReg, l1Reg, l2Reg;
  logic          wrReg, privReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaReg   <= '0;
      baseReg <= '0;
      wrReg   <= 1'b0;
      privReg <= 1'b0;
      l1Reg   <= '0;
      l2Reg   <= '0;
    end else begin
      if (st.capReq) begin
        vaReg   <= reqVaddr;
        baseReg <= reqVaddr[AW-1] ? globalBase : localBase;
        wrReg   <= reqWrite;
        privReg <= reqPriv;
      end
      if (st.capL1) l1Reg <= memRspData;
      if (st.capL2) l2Reg <= memRspData;
    end
  end

  // classification
  logic [AW-1:0] halfAddr;
  assign halfAddr  = vaReg & HALF_MASK;
  assign isInvalid = (vaReg <= INV_LO_LAST) || (vaReg >= INV_HI_FIRST);
  assign isBypass  = halfAddr < BYPASS_SIZE;

  // first level
  logic [AW-1:0] l1Addr;
  assign l1Addr = baseReg + ((halfAddr >> REGION_SHIFT) << 2);

  logic [SIZE_W-1:0] sizeCode;
  logic [5:0]        pageShift;
  logic [AW-1:0]     offMask, l2Addr;
  assign sizeCode  = l1Reg[SIZE_LSB +: SIZE_W];
  assign l1Valid   = l1Reg[ENT_VALID];
  assign l1SizeOk  = 32'(sizeCode) <= MAX_CODE;
  assign pageShift = 6'(MIN_SHIFT) + 6'(sizeCode);
  assign offMask   = (AW'(1) << pageShift) - AW'(1);
  assign l2Addr    = (l1Reg & ~TBL_MASK) + (((vaReg & REGION_MASK) >> pageShift) << 2);

  assign memAddr = st.useL2 ? l2Addr : l1Addr;

  // leaf checks
  assign l2Valid   = l2Reg[ENT_VALID];
  assign privViol  = l2Reg[ENT_PRIV] && !privReg;
  assign writeViol = wrReg && !l2Reg[ENT_WRITE];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resPaddr <= '0;
      resWin   <= '0;
      resWc    <= 1'b0;
      resFault <= FLT_NONE;
    end else if (st.finBypass) begin
      resPaddr <= vaReg;
      resWin   <= '0;
      resWc    <= 1'b0;
      resFault <= FLT_NONE;
    end else if (st.finLeaf) begin
      resPaddr <= (l2Reg & ~offMask) | (vaReg & offMask);
      resWin   <= l2Reg[WIN_LSB +: WIN_W];
      resWc    <= l2Reg[ENT_WC];
      resFault <= FLT_NONE;
    end else if (st.finFault) begin
      resPaddr <= '0;
      resWin   <= '0;
      resWc    <= 1'b0;
      resFault <= st.code;
    end
  end
endmodule

// File: rtl/walker_ctrl.sv
module walker_ctrl
  import walker_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    memReqReady,
  input  logic    memRspValid,
  input  logic    isInvalid,
  input  logic    isBypass,
  input  logic    l1Valid,
  input  logic    l1SizeOk,
  input  logic    l2Valid,
  input  logic    privViol,
  input  logic    writeViol,
  output logic    reqReady,
  output logic    memReqValid,
  output logic    doneValid,
  output strobe_t st
);
  typedef enum logic [3:0] {
    S_IDLE, S_CHECK, S_L1REQ, S_L1WAIT, S_L1CHK,
    S_L2REQ, S_L2WAIT, S_LEAF, S_DONE
  } state_e;

  state_e state, nxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end

  assign reqReady    = (state == S_IDLE);
  assign memReqValid = (state == S_L1REQ) || (state == S_L2REQ);
  assign doneValid   = (state == S_DONE);

  always_comb begin
    nxt = state;
    st  = '0;
    case (state)
      S_IDLE: if (reqValid) begin
        st.capReq = 1'b1;
        nxt = S_CHECK;
      end
      S_CHECK: begin
        if (isInvalid) begin
          st.finFault = 1'b1;
          st.code     = FLT_INVALID;
          nxt = S_DONE;
        end else if (isBypass) begin
          st.finBypass = 1'b1;
          nxt = S_DONE;
        end else begin
          nxt = S_L1REQ;
        end
      end
      S_L1REQ: if (memReqReady) nxt = S_L1WAIT;
      S_L1WAIT: if (memRspValid) begin
        st.capL1 = 1'b1;
        nxt = S_L1CHK;
      end
      S_L1CHK: begin
        if (!l1Valid) begin
          st.finFault = 1'b1;
          st.code     = FLT_ABSENT;
          nxt = S_DONE;
        end else if (!l1SizeOk) begin
          st.finFault = 1'b1;
          st.code     = FLT_SIZE;
          nxt = S_DONE;
        end else begin
          nxt = S_L2REQ;
        end
      end
      S_L2REQ: begin
        st.useL2 = 1'b1;
        if (memReqReady) nxt = S_L2WAIT;
      end
      S_L2WAIT: if (memRspValid) begin
        st.capL2 = 1'b1;
        nxt = S_LEAF;
      end
      S_LEAF: begin
        nxt = S_DONE;
        if (!l2Valid) begin
          st.finFault = 1'b1;
          st.code     = FLT_ABSENT;
        end else if (privViol) begin
          st.finFault = 1'b1;
          st.code     = FLT_PRIV;
        end else if (writeViol) begin
          st.finFault = 1'b1;
          st.code     = FLT_WRPROT;
        end else begin
          st.finLeaf = 1'b1;
        end
      end
      S_DONE: nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end
endmodule

// File: rtl/vpage_walker.sv
module vpage_walker
  import walker_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic [31:0] reqVaddr,
  input  logic        reqWrite,
  input  logic        reqPriv,
  input  logic [31:0] localBase,
  input  logic [31:0] globalBase,
  output logic        memReqValid,
  input  logic        memReqReady,
  output logic [31:0] memReqAddr,
  input  logic        memRspValid,
  input  logic [31:0] memRspData,
  output logic        doneValid,
  output logic [31:0] donePaddr,
  output logic [1:0]  doneWin,
  output logic        doneWc,
  output logic [2:0]  doneFault
);
  strobe_t st;
  logic    isInvalid, isBypass, l1Valid, l1SizeOk, l2Valid, privViol, writeViol;
  fault_e  resFault;

  walker_ctrl u_ctrl (
    .clk, .rstN, .reqValid, .memReqReady, .memRspValid,
    .isInvalid, .isBypass, .l1Valid, .l1SizeOk, .l2Valid,
    .privViol, .writeViol,
    .reqReady, .memReqValid, .doneValid, .st
  );

  walker_dp u_dp (
    .clk, .rstN, .st, .reqVaddr, .reqWrite, .reqPriv,
    .localBase, .globalBase, .memRspData,
    .isInvalid, .isBypass, .l1Valid, .l1SizeOk, .l2Valid,
    .privViol, .writeViol,
    .memAddr(memReqAddr), .resPaddr(donePaddr), .resWin(doneWin),
    .resWc(doneWc), .resFault
  );

  assign doneFault = resFault;
endmodule

// File: rtl/walker_chk.sv
module walker_chk (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqReady,
  input logic [31:0] reqVaddr,
  input logic        memReqValid,
  input logic        memReqReady,
  input logic [31:0] memReqAddr,
  input logic        doneValid,
  input logic [31:0] donePaddr,
  input logic [1:0]  doneWin,
  input logic        doneWc,
  input logic [2:0]  doneFault
);
  logic        busy, pendInvalid, pendBypass;
  logic [31:0] pendAddr;
  logic        accInvalid, accBypass;

  assign accInvalid = (reqVaddr < 32'h0020_0000) || (reqVaddr > 32'hFFFE_FFFF);
  assign accBypass  = !accInvalid && (reqVaddr[30:27] == 4'd0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      pendInvalid <= 1'b0;
      pendBypass  <= 1'b0;
      pendAddr    <= '0;
    end else if (reqValid && reqReady) begin
      busy <= 1'b1;
      pendInvalid <= accInvalid;
      pendBypass  <= accBypass;
      pendAddr    <= reqVaddr;
    end else if (doneValid) begin
      busy <= 1'b0;
    end
  end

  p_no_read_r1: assert property (@(posedge clk) disable iff (!rstN)
    busy && pendInvalid |-> !memReqValid);
  p_invalid_code_r1: assert property (@(posedge clk) disable iff (!rstN)
    doneValid && busy && pendInvalid |-> doneFault == 3'd1);
  p_bypass_noread_r2: assert property (@(posedge clk) disable iff (!rstN)
    busy && pendBypass |-> !memReqValid);
  p_bypass_addr_r2: assert property (@(posedge clk) disable iff (!rstN)
    doneValid && busy && pendBypass |-> donePaddr == pendAddr && doneFault == 3'd0);
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqAddr));
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);
  p_busy_ready_r11: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !reqReady);
  p_fault_zero_r11: assert property (@(posedge clk) disable iff (!rstN)
    doneValid && doneFault != 3'd0 |-> donePaddr == 32'd0 && doneWin == 2'd0 && !doneWc);
endmodule

bind vpage_walker walker_chk u_chk (
  .clk, .rstN, .reqValid, .reqReady, .reqVaddr,
  .memReqValid, .memReqReady, .memReqAddr,
  .doneValid, .donePaddr, .doneWin, .doneWc, .doneFault
);

// File: tb/test_vpage_walker.sv
`timescale 1ns/1ps
module test_vpage_walker;
  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid, reqWrite, reqPriv;
  logic        reqReady;
  logic [31:0] reqVaddr, localBase, globalBase;
  logic        memReqValid, memReqReady, memRspValid;
  logic [31:0] memReqAddr, memRspData;
  logic        doneValid, doneWc;
  logic [31:0] donePaddr;
  logic [1:0]  doneWin;
  logic [2:0]  doneFault;

  always #2 clk = ~clk;

  vpage_walker i_vpage_walker (.*);

  typedef struct {
    logic [31:0] paddr;
    logic [1:0]  win;
    logic        wc;
    logic [2:0]  fault;
    int          reads;
    int          readBase;
    logic [31:0] va;
  } exp_t;

  exp_t        sbq[$];
  logic [31:0] mem [logic [31:0]];
  int          checks = 0, fails = 0, readCount = 0;
  bit          finished = 0;

  localparam logic [31:0] LB = 32'h0010_0000;
  localparam logic [31:0] GB = 32'h0020_0000;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'd0;
  endfunction

  function automatic logic [31:0] l1A(input logic [31:0] va);
    return (va[31] ? GB : LB) + (((va & 32'h7FFF_FFFF) >> 22) << 2);   // R3
  endfunction

  function automatic logic [31:0] l2A(input logic [31:0] e1, input logic [31:0] va);
    int sh = 12 + int'(e1[4:1]);
    return (e1 & 32'hFFFF_F000) + (((va & 32'h003F_FFFF) >> sh) << 2);  // R6
  endfunction

  task automatic mapPage(input logic [31:0] va, input logic [31:0] tab, input int code,
                         input logic [31:0] leaf);
    logic [31:0] e1 = tab | (32'(code) << 1) | 32'd1;
    mem[l1A(va)] = e1;
    mem[l2A(e1, va)] = leaf;
  endtask

  function automatic exp_t model(input logic [31:0] va, input bit wr, input bit pv);
    exp_t e;
    logic [31:0] e1, e2, m;
    int sh;
    e.paddr = 0; e.win = 0; e.wc = 0; e.fault = 0; e.reads = 0; e.va = va; e.readBase = 0;
    if (va < 32'h0020_0000 || va >= 32'hFFFF_0000) begin e.fault = 1; return e; end  // R1
    if ((va & 32'h7FFF_FFFF) < 32'h0800_0000) begin e.paddr = va; return e; end      // R2
    e.reads = 1;
    e1 = rd(l1A(va));
    if (!e1[0]) begin e.fault = 2; return e; end                                       // R4
    if (e1[4:1] > 4'd10) begin e.fault = 5; return e; end                              // R5
    e.reads = 2;
    e2 = rd(l2A(e1, va));
    if (!e2[0]) begin e.fault = 2; return e; end
    if (e2[2] && !pv) begin e.fault = 4; return e; end                                 // R8
    if (wr && !e2[1]) begin e.fault = 3; return e; end                                 // R9
    sh = 12 + int'(e1[4:1]);
    m = (32'd1 << sh) - 32'd1;
    e.paddr = (e2 & ~m) | (va & m);                                                    // R7
    e.win = e2[7:6];
    e.wc = e2[3];
    return e;
  endfunction

  // driver: one request at a time
  task automatic translate(input logic [31:0] va, input bit wr, input bit pv);
    exp_t e;
    while (sbq.size() != 0) @(negedge clk);
    @(negedge clk);
    check(reqReady === 1'b1, "R11 ready when idle", 32'(reqReady), 32'd1);
    e = model(va, wr, pv);
    e.readBase = readCount;
    sbq.push_back(e);
    reqVaddr = va; reqWrite = wr; reqPriv = pv; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    reqVaddr = 32'hDEAD_BEEF;
  endtask

  // memory model with stalls; also checks R10 hold
  initial begin
    bit          pend = 0, lastStall = 0;
    logic [31:0] pAddr = 0, lastAddr = 0;
    int          cyc = 0;
    memReqReady = 1'b0; memRspValid = 1'b0; memRspData = '0;
    forever begin
      @(negedge clk);
      if (lastStall) begin
        check(memReqValid === 1'b1 && memReqAddr === lastAddr, "R10 request held",
              memReqAddr, lastAddr);
      end
      memRspValid = 1'b0;
      if (pend) begin
        memRspValid = 1'b1;
        memRspData = rd(pAddr);
        pend = 0;
      end
      cyc++;
      memReqReady = (cyc % 3) != 0;
      lastStall = memReqValid && !memReqReady;
      lastAddr = memReqAddr;
      if (memReqValid && memReqReady) begin
        pend = 1;
        pAddr = memReqAddr;
        readCount++;
      end
    end
  end

  // monitor / scoreboard
  initial begin
    bit prevDone = 0;
    forever begin
      @(negedge clk);
      if (rstN && doneValid) begin
        exp_t e;
        check(!prevDone, "R11 done single cycle", 32'(prevDone), 32'd0);
        check(reqReady === 1'b0, "R11 not ready at done", 32'(reqReady), 32'd0);
        if (sbq.size() == 0) begin
          check(1'b0, "R11 unexpected done", 32'd1, 32'd0);
        end else begin
          e = sbq.pop_front();
          check(doneFault === e.fault, $sformatf("R1/R4/R5/R8/R9 fault va=%h", e.va),
                32'(doneFault), 32'(e.fault));
          check(donePaddr === e.paddr, $sformatf("R2/R7 paddr va=%h", e.va), donePaddr, e.paddr);
          check(doneWin === e.win, $sformatf("R7 window va=%h", e.va), 32'(doneWin), 32'(e.win));
          check(doneWc === e.wc, $sformatf("R7 wc va=%h", e.va), 32'(doneWc), 32'(e.wc));
          check(readCount - e.readBase == e.reads, $sformatf("R3/R6 reads va=%h", e.va),
                32'(readCount - e.readBase), 32'(e.reads));
        end
      end
      prevDone = doneValid;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; reqValid = 1'b0; reqWrite = 1'b0; reqPriv = 1'b0; reqVaddr = '0;
    localBase = LB; globalBase = GB;
    // page tables
    mapPage(32'h0840_3ABC, 32'h0030_0000, 0,  32'h1234_5000 | 32'hC0 | 32'h8 | 32'h2 | 32'h1);
    mapPage(32'h9234_5678, 32'h0031_0000, 4,  32'h4567_0000 | 32'h40 | 32'h1);
    mapPage(32'h1ABC_DEF0, 32'h0032_0000, 10, 32'h7FC0_0000 | 32'h80 | 32'h8 | 32'h2 | 32'h1);
    mapPage(32'h4800_1000, 32'h0033_0000, 2,  32'h0ABC_C000 | 32'h40 | 32'h4 | 32'h2 | 32'h1);
    mapPage(32'h4880_2000, 32'h0036_0000, 1,  32'h0DEF_0000 | 32'h4 | 32'h1);
    mapPage(32'h2840_0000, 32'h0034_0000, 0,  32'h0000_0000);
    mem[l1A(32'h3000_0000)] = 32'h0035_0000 | (32'd11 << 1) | 32'd1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12 reset state
    check(reqReady === 1'b1, "R12 reset reqReady", 32'(reqReady), 32'd1);
    check(doneValid === 1'b0, "R12 reset doneValid", 32'(doneValid), 32'd0);
    check(memReqValid === 1'b0, "R12 reset memReqValid", 32'(memReqValid), 32'd0);
    rstN = 1'b1;
    // R1 invalid windows and boundaries
    translate(32'h0000_1000, 0, 0);
    translate(32'h001F_FFFF, 0, 1);
    translate(32'hFFFF_0000, 1, 1);
    // R2 bypass, including edge just above invalid window
    translate(32'h0020_0000, 0, 0);
    translate(32'h07FF_FFFC, 1, 0);
    translate(32'h8123_4567, 0, 0);
    // R3 R6 R7 translated walks
    translate(32'h0840_3ABC, 0, 0);
    translate(32'h0840_3ABC, 1, 0);
    translate(32'h9234_5678, 0, 0);
    translate(32'h1ABC_DEF0, 1, 1);
    // R9 write protect
    translate(32'h9234_5678, 1, 0);
    // R8 privilege and its priority over R9
    translate(32'h4800_1000, 0, 0);
    translate(32'h4800_1000, 1, 1);
    translate(32'h4880_2000, 1, 0);
    translate(32'h4880_2000, 1, 1);
    // R4 not present at each level, R5 bad size
    translate(32'h2000_0000, 0, 0);
    translate(32'h2840_0000, 0, 0);
    translate(32'h3000_0000, 0, 0);
    while (sbq.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule